// File: doc/BRIEF.md
# Burst Read Wait-State Sequencer

This block produces the read-side timing of a synchronous burst memory. A request carries a start word address, a first-access latency choice and a high-frequency flag. From these it decides, cycle by cycle, whether a data word is presented or the data-ready strobe is held low. After the programmed first-access delay it walks linearly upward through the address space and presents one word per clock. It stretches the stream with wait cycles in two cases: once when the start address is not aligned to a four-word group, and each time the walk steps across a 128-word region edge while the high-frequency flag is set.

The storage behind the sequencer is a synthesizable stand-in. Each word it returns is a fixed function of its address, so the whole stream can be predicted from the request alone. A new request at any time restarts the sequence. Dropping the chip enable parks the block.

Top module: `burst_wait_seq`

## Requirements
- R1: While reset is asserted and in the cycle after it, `rdy` is 0 and `rd_data` is 0.
- R2: A request is taken at a clock edge where `chip_en` and `burst_req` are both 1. `rdy` is then 0 for exactly L cycles, and the first word follows with `word_addr` equal to the start address. L is 5, 6 or 7 for `lat_sel` values 0, 1 and 2; value 3 behaves as 7.
- R3: For a start address whose two low bits are 00, words follow each other on consecutive cycles with `rdy` high, unless a region wait from R6 applies.
- R4: For a start address whose two low bits are k (1, 2 or 3), the words up to the last word of that four-word group (low bits 11) are delivered back to back. Then exactly k cycles with `rdy` low follow before the next word. No later group boundary adds an alignment wait.
- R5: Each presented word's address is one above the previous presented word of the same burst. The walk continues across four-word groups and wraps from the all-ones address to 0.
- R6: If `hf_mode` was 1 at the request, stepping from an address whose low seven bits are all ones to the next address adds one more `rdy`-low cycle, summed with any R4 waits. If `hf_mode` was 0, no such wait is added.
- R7: While `rdy` is 1, `rd_data` equals the low 16 bits of `word_addr` XOR 16'hA5C3. While `rdy` is 0, `rd_data` is 0.
- R8: A request accepted while a burst is active discards it and restarts at R2 from the new address, whether the old burst was in its latency, in a wait or presenting data.
- R9: With `chip_en` 0 at an edge, `rdy` is 0 after that edge. The block stays idle, ignoring `burst_req`, until a request is taken with `chip_en` 1. Raising `chip_en` alone starts nothing.
- R10: `lat_sel`, `hf_mode` and `start_addr` are used only at the request edge. Changing them during a burst does not alter its timing or addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| chip_en | input | 1 | Enable; low parks the block idle |
| burst_req | input | 1 | Start a burst from `start_addr` at this edge |
| start_addr | input | 24 | Word address of the first word |
| lat_sel | input | 2 | First-access latency: 0→5, 1→6, 2/3→7 cycles |
| hf_mode | input | 1 | Add a wait when crossing a 128-word region |
| rdy | output | 1 | High on cycles that present a valid word |
| word_addr | output | 24 | Address of the word being presented |
| rd_data | output | 16 | Word data, 0 when `rdy` is low |

## Verification
The bench aims at the places where the wait pattern changes shape. These are starts at each of the four group offsets, groups that end exactly on a 128-word edge with the high-frequency flag both set and clear, and a start two words below the top of the address space so that the walk wraps while waits are pending. A design that reapplied alignment waits at every group, or that replaced the alignment wait with the region wait instead of adding them, would hold `rdy` low for the wrong number of cycles. An off-by-one in the latency counter would shift every word by a cycle. The bench also issues requests in the middle of latency and data phases, and changes the per-request inputs during bursts. These catch a design that finishes the old burst or samples its settings live, and a design that accepts a request while disabled shows up as `rdy` rising during the idle window.

// File: rtl/bsq_pkg.sv
// Package: shared types for the burst wait-state sequencer.
// Assumes nothing beyond standard SystemVerilog.
package bsq_pkg;

    // Sequencer phase: idle, counting low cycles, or presenting a word
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HOLD = 2'd1,
        PH_BEAT = 2'd2
    } phase_t;

endpackage

// File: rtl/bsq_latency_dec.sv
// Module: bsq_latency_dec
// Turns the latency selector into a cycle count. Selector values past the
// last step saturate at the longest latency.
// Assumes CNT_W can hold LAT_MIN + LAT_STEPS - 1.
module bsq_latency_dec #(
    parameter int LAT_MIN   = 5,
    parameter int LAT_STEPS = 3,
    parameter int SEL_W     = 2,
    parameter int CNT_W     = 3
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] cycles
);
    localparam int LAT_MAX = LAT_MIN + LAT_STEPS - 1;

    // Purpose: map selector to cycles with saturation at the top step
    always_comb begin
        if (int'(sel) >= LAT_STEPS - 1)
            cycles = CNT_W'(LAT_MAX);
        else
            cycles = CNT_W'(LAT_MIN + int'(sel));
    end
endmodule

// File: rtl/bsq_wait_calc.sv
// Module: bsq_wait_calc
// Number of low cycles to insert after the word at addr before the next one.
// Alignment waits apply only at the end of the starting group; the region
// wait applies at every region edge when the fast option is latched.
// Assumes CNT_W can hold 2**GROUP_W.
module bsq_wait_calc #(
    parameter int ADDR_W   = 24,
    parameter int GROUP_W  = 2,
    parameter int REGION_W = 7,
    parameter int CNT_W    = 3
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               first_grp,
    input  logic [GROUP_W-1:0] offset,
    input  logic               hf,
    output logic [CNT_W-1:0]   waits,
    output logic               group_end
);
    logic region_end;
    logic [CNT_W-1:0] align_w;
    logic [CNT_W-1:0] region_w;

    // Purpose: detect last word of a group and of a region
    always_comb begin
        group_end  = &addr[GROUP_W-1:0];
        region_end = &addr[REGION_W-1:0];
    end

    // Purpose: sum alignment and region waits for this step
    always_comb begin
        align_w  = (first_grp && group_end) ? CNT_W'(offset) : '0;
        region_w = (hf && region_end) ? CNT_W'(1) : '0;
        waits    = align_w + region_w;
    end
endmodule

// File: rtl/bsq_word_source.sv
// Module: bsq_word_source
// Stand-in storage: the word at an address is its low bits XOR a key.
// Output is forced to zero when no word is being presented.
// Assumes ADDR_W >= DATA_W.
module bsq_word_source #(
    parameter int                ADDR_W = 24,
    parameter int                DATA_W = 16,
    parameter logic [DATA_W-1:0] KEY    = 16'hA5C3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              valid,
    output logic [DATA_W-1:0] data
);
    // Purpose: compute the word and gate it with valid
    always_comb begin
        data = valid ? (addr[DATA_W-1:0] ^ KEY) : '0;
    end
endmodule

// File: rtl/burst_wait_seq.sv
// Module: burst_wait_seq (top)
// Burst read sequencer. Accepts a request, holds rdy low for the programmed
// first-access latency, then steps the address upward one word per cycle,
// inserting alignment and region-crossing waits. Request settings are
// latched at the request edge. chip_en low parks the block.
// Assumes a synchronous active-low reset and a single clock.
module burst_wait_seq #(
    parameter int                ADDR_W    = 24,
    parameter int                DATA_W    = 16,
    parameter int                GROUP_W   = 2,
    parameter int                REGION_W  = 7,
    parameter int                LAT_MIN   = 5,
    parameter int                LAT_STEPS = 3,
    parameter int                SEL_W     = 2,
    parameter logic [DATA_W-1:0] KEY       = 16'hA5C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              burst_req,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [SEL_W-1:0]  lat_sel,
    input  logic              hf_mode,
    output logic              rdy,
    output logic [ADDR_W-1:0] word_addr,
    output logic [DATA_W-1:0] rd_data
);
    import bsq_pkg::*;

    localparam int LAT_MAX  = LAT_MIN + LAT_STEPS - 1;
    localparam int WAIT_MAX = (1 << GROUP_W);
    localparam int CNT_TOP  = (LAT_MAX > WAIT_MAX) ? LAT_MAX : WAIT_MAX;
    localparam int CNT_W    = $clog2(CNT_TOP + 1);

    phase_t             phase;
    logic [CNT_W-1:0]   gap;
    logic [ADDR_W-1:0]  cur_addr;
    logic               first_grp;
    logic [GROUP_W-1:0] off_q;
    logic               hf_q;

    logic [CNT_W-1:0]   lat_cycles;
    logic [CNT_W-1:0]   step_waits;
    logic               at_group_end;

    bsq_latency_dec #(
        .LAT_MIN   (LAT_MIN),
        .LAT_STEPS (LAT_STEPS),
        .SEL_W     (SEL_W),
        .CNT_W     (CNT_W)
    ) u_lat (
        .sel    (lat_sel),
        .cycles (lat_cycles)
    );

    bsq_wait_calc #(
        .ADDR_W   (ADDR_W),
        .GROUP_W  (GROUP_W),
        .REGION_W (REGION_W),
        .CNT_W    (CNT_W)
    ) u_wait (
        .addr      (cur_addr),
        .first_grp (first_grp),
        .offset    (off_q),
        .hf        (hf_q),
        .waits     (step_waits),
        .group_end (at_group_end)
    );

    // Purpose: phase, counter and address sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            gap       <= '0;
            cur_addr  <= '0;
            first_grp <= 1'b0;
            off_q     <= '0;
            hf_q      <= 1'b0;
        end else if (!chip_en) begin
            phase <= PH_IDLE;
        end else if (burst_req) begin
            phase     <= PH_HOLD;
            gap       <= lat_cycles - CNT_W'(1);
            cur_addr  <= start_addr;
            first_grp <= 1'b1;
            off_q     <= start_addr[GROUP_W-1:0];
            hf_q      <= hf_mode;
        end else begin
            case (phase)
                PH_HOLD: begin
                    if (gap == '0)
                        phase <= PH_BEAT;
                    else
                        gap <= gap - CNT_W'(1);
                end
                PH_BEAT: begin
                    cur_addr <= cur_addr + ADDR_W'(1);
                    if (at_group_end)
                        first_grp <= 1'b0;
                    if (step_waits != '0) begin
                        phase <= PH_HOLD;
                        gap   <= step_waits - CNT_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Purpose: drive strobe and address from state
    always_comb begin
        rdy       = (phase == PH_BEAT);
        word_addr = cur_addr;
    end

    bsq_word_source #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .KEY    (KEY)
    ) u_src (
        .addr  (cur_addr),
        .valid (rdy),
        .data  (rd_data)
    );
endmodule

// File: rtl/bsq_checker.sv
// Module: bsq_checker
// Temporal checks on the sequencer ports, bound into burst_wait_seq.
module bsq_checker #(
    parameter int                ADDR_W  = 24,
    parameter int                DATA_W  = 16,
    parameter int                GROUP_W = 2,
    parameter logic [DATA_W-1:0] KEY     = 16'hA5C3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_en,
    input logic              burst_req,
    input logic [ADDR_W-1:0] start_addr,
    input logic              rdy,
    input logic [ADDR_W-1:0] word_addr,
    input logic [DATA_W-1:0] rd_data
);
    p_disable_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> !rdy);

    p_request_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && burst_req) |=> !rdy);

    p_restart_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && burst_req) |=> (word_addr == $past(start_addr)));

    p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && chip_en && !burst_req) |=> (word_addr == $past(word_addr) + ADDR_W'(1)));

    p_no_mid_group_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && chip_en && !burst_req && !(&word_addr[GROUP_W-1:0])) |=> rdy);

    p_data_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> (rd_data == (word_addr[DATA_W-1:0] ^ KEY)));

    p_data_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> (rd_data == '0));
endmodule

bind burst_wait_seq bsq_checker #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .GROUP_W (GROUP_W),
    .KEY     (KEY)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_en    (chip_en),
    .burst_req  (burst_req),
    .start_addr (start_addr),
    .rdy        (rdy),
    .word_addr  (word_addr),
    .rd_data    (rd_data)
);

// File: tb/sim_burst_wait_seq.sv
`timescale 1ns/100ps
module sim_burst_wait_seq;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam logic [DW-1:0] KEY = 16'hA5C3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_en = 1'b0;
    logic          burst_req = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [1:0]    lat_sel = '0;
    logic          hf_mode = 1'b0;
    logic          rdy;
    logic [AW-1:0] word_addr;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    burst_wait_seq u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_en    (chip_en),
        .burst_req  (burst_req),
        .start_addr (start_addr),
        .lat_sel    (lat_sel),
        .hf_mode    (hf_mode),
        .rdy        (rdy),
        .word_addr  (word_addr),
        .rd_data    (rd_data)
    );

    function automatic int exp_lat(input logic [1:0] sel);
        return (sel >= 2'd2) ? 7 : 5 + int'(sel);
    endfunction

    function automatic logic [DW-1:0] exp_data(input logic [AW-1:0] a);
        return a[DW-1:0] ^ KEY;
    endfunction

    function automatic int exp_gap(input logic [AW-1:0] a, input bit first,
                                   input logic [1:0] off, input bit hf);
        int g = 0;
        if (first && a[1:0] == 2'b11) g += int'(off);
        if (hf && a[6:0] == 7'h7F) g += 1;
        return g;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One burst: request, then check every cycle until nwords are seen.
    // Request inputs are scrambled after the request edge (R10).
    task automatic run_burst(input logic [AW-1:0] a0, input logic [1:0] sel,
                             input bit hf, input int nwords, input string tag);
        int low;
        int got;
        bit first;
        logic [AW-1:0] a;
        @(negedge clk);
        chip_en = 1'b1; burst_req = 1'b1;
        start_addr = a0; lat_sel = sel; hf_mode = hf;
        @(negedge clk);
        burst_req = 1'b0;
        lat_sel = 2'($urandom); hf_mode = 1'($urandom); start_addr = AW'($urandom);
        low = exp_lat(sel); a = a0; first = 1; got = 0;
        while (got < nwords) begin
            if (low > 0) begin
                chk(rdy == 1'b0, tag, "rdy low in hold", rdy, 0);
                chk(rd_data == '0, "R7", "data zero in hold", rd_data, 0);
                low--;
            end else begin
                chk(rdy == 1'b1, tag, "rdy high on word", rdy, 1);
                chk(word_addr == a, "R5", "word address", word_addr, a);
                chk(rd_data == exp_data(a), "R7", "word data", rd_data, exp_data(a));
                low = exp_gap(a, first, a0[1:0], hf);
                if (a[1:0] == 2'b11) first = 0;
                a = a + AW'(1);
                got++;
            end
            if (got < nwords) @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(rdy == 1'b0, "R1", "rdy in reset", rdy, 0);
        chk(rd_data == '0, "R1", "data in reset", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdy == 1'b0, "R1", "rdy after reset", rdy, 0);

        // R2: each latency setting, including saturating value 3
        run_burst(24'h000100, 2'd0, 1'b0, 4, "R2");
        run_burst(24'h000110, 2'd1, 1'b0, 4, "R2");
        run_burst(24'h000120, 2'd2, 1'b0, 4, "R2");
        run_burst(24'h000130, 2'd3, 1'b0, 4, "R2");

        // R3: aligned start, continuous words
        run_burst(24'h000204, 2'd0, 1'b0, 9, "R3");

        // R4: each misaligned offset
        run_burst(24'h000301, 2'd0, 1'b0, 10, "R4");
        run_burst(24'h000322, 2'd1, 1'b0, 10, "R4");
        run_burst(24'h000343, 2'd2, 1'b0, 10, "R4");

        // R6: region edge with fast option set and clear
        run_burst(24'h00007C, 2'd0, 1'b1, 8, "R6");
        run_burst(24'h00017D, 2'd1, 1'b1, 8, "R6");
        run_burst(24'h00027F, 2'd0, 1'b1, 4, "R6");
        run_burst(24'h00037D, 2'd0, 1'b0, 8, "R6");

        // R5: wrap at the top of the address space with waits pending
        run_burst(24'hFFFFFE, 2'd0, 1'b1, 6, "R5");

        // R8: abort during latency, then during data
        run_burst(24'h000500, 2'd2, 1'b0, 0, "R8");
        run_burst(24'h000603, 2'd0, 1'b1, 2, "R8");
        run_burst(24'h000781, 2'd1, 1'b0, 6, "R8");

        // R9: disable mid-burst, request while disabled, re-enable alone
        run_burst(24'h000800, 2'd0, 1'b0, 3, "R9");
        @(negedge clk);
        chip_en = 1'b0;
        @(negedge clk);
        chk(rdy == 1'b0, "R9", "rdy after disable", rdy, 0);
        burst_req = 1'b1; start_addr = 24'h000900;
        @(negedge clk);
        burst_req = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(rdy == 1'b0, "R9", "idle while disabled", rdy, 0);
        end
        chip_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(rdy == 1'b0, "R9", "idle after enable", rdy, 0);
        end
        run_burst(24'h000A02, 2'd0, 1'b1, 5, "R9");

        // R10 and mixed: random bursts, often near region edges
        for (int n = 0; n < 40; n++) begin
            logic [AW-1:0] ra;
            ra = AW'($urandom);
            if ($urandom % 2 == 0) ra[6:0] = 7'd124 + 7'($urandom % 4);
            run_burst(ra, 2'($urandom), 1'($urandom), 1 + int'($urandom % 12), "R10");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule